// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block turns the fill levels of a UART's transmit and receive FIFOs into interrupt requests. It combines them with five event sources: receive timeout, framing error, parity error, break and overrun. It keeps three views of the interrupt sources: a raw status word, a software-programmed enable mask, and the masked status (raw AND mask). It drives one combined interrupt line, which is the OR of the masked status. The FIFOs, the serial engines and the bus adapter sit outside this block. They supply occupancy counts and single-cycle event pulses, and they access the registers through a simple write strobe and read strobe that share one address.

The receive source is active while receive occupancy is at or above a programmed fraction of FIFO depth. The transmit source is active while transmit occupancy is at or below its programmed fraction. Each fraction is chosen by a 3-bit code. The two level-derived bits follow their conditions every cycle. The five event bits are sticky: each holds until software writes a 1 to the matching bit of the clear register.

The block has no state machine. Its only sequential elements are the level-select register, the mask register and the five sticky event flops. Each sticky flop has two states, idle and pending: a pulse moves it to pending, and a clear write without a simultaneous pulse moves it back to idle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the level-select register reads 0x12 (both codes = 2), the mask reads 0, all sticky event bits are 0, and `irq` is 0.
- R2: Raw bit 4 (receive) is 1 exactly when `rx_level` >= T(rxcode). The rxcode is level-select bits 5:3. T(c) = DEPTH/8 × {1,2,4,6,7} for c = 0..4.
- R3: Raw bit 5 (transmit) is 1 exactly when `tx_level` <= T(txcode). The txcode is level-select bits 2:0, and T is the same table as in R2.
- R4: Codes 5, 6 and 7 in either field act as code 2 (half of DEPTH).
- R5: An event pulse sets its raw bit on the next clock, and the bit stays set. The bit positions are timeout 6, framing 7, parity 8, break 9 and overrun 10.
- R6: Writing address 2 (clear) with a 1 in bit positions 10:6 clears those sticky bits. Bits written as 0, and bits 5:4, have no effect.
- R7: When an event pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R8: Address 1 (mask) stores only bits 10:4, and bits 3:0 read 0. Address 4 reads raw AND mask, and address 3 reads raw. Raw bits 3:0 are always 0.
- R9: `irq` is 1 exactly when any bit of raw AND mask is 1.
- R10: `rd_data` is 0 while `rd_en` is low. Writes to addresses 3 and 4 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_break | input | 1 | Break detected pulse |
| ev_overrun | input | 1 | Overrun pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 level select, 1 mask, 2 clear, 3 raw, 4 masked |
| wr_data | input | 11 | Write data |
| rd_data | output | 11 | Read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker checks the following on every cycle: that a full receive FIFO always raises the receive bit, that an empty one never does, the mirror-image conditions for transmit, that event pulses latch, that pending bits persist unless cleared, that a clear takes effect, and that `irq` agrees with raw AND mask. Only the bench scenarios show the exact threshold boundaries for every code, the reserved-code fallback, the priority of a pulse over a same-cycle clear, and that writes to read-only addresses and reads with the strobe low leave everything untouched.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IRQ_W = 11;
    localparam int EV_N  = 5;

    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_RTO = 6;
    localparam int B_FE  = 7;
    localparam int B_PE  = 8;
    localparam int B_BE  = 9;
    localparam int B_OE  = 10;

    localparam logic [IRQ_W-1:0] LIVE_BITS = 11'h7F0;
    localparam logic [5:0]       LVL_RESET = 6'b010_010;

    typedef enum logic [2:0] {
        A_LEVEL = 3'd0,
        A_MASK  = 3'd1,
        A_CLEAR = 3'd2,
        A_RAW   = 3'd3,
        A_MSTAT = 3'd4
    } reg_addr_e;

    // Number of eighths of FIFO depth selected by a threshold code.
    function automatic int unsigned eighths(input logic [2:0] code);
        unique case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 4;  // code 2 and reserved codes 5..7
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic [2:0]       code,
    input  logic [CNT_W-1:0] level,
    output logic             hit
);
    import uart_irq_pkg::*;

    localparam int STEP = DEPTH / 8;

    logic [CNT_W-1:0] thr;

    always_comb begin
        thr = CNT_W'(eighths(code) * STEP);
    end

    generate
        if (AT_LEAST) begin : g_ge
            assign hit = (level >= thr);
        end else begin : g_le
            assign hit = (level <= thr);
        end
    endgenerate

endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic [N-1:0] clr_pulse,
    output logic [N-1:0] pending
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pending[i] <= 1'b0;
                end else if (set_pulse[i]) begin
                    pending[i] <= 1'b1;
                end else if (clr_pulse[i]) begin
                    pending[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
    parameter  int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             ev_rx_timeout,
    input  logic             ev_frame_err,
    input  logic             ev_parity_err,
    input  logic             ev_break,
    input  logic             ev_overrun,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       reg_addr,
    input  logic [10:0]      wr_data,
    output logic [10:0]      rd_data,
    output logic             irq
);
    import uart_irq_pkg::*;

    generate
        if (DEPTH % 8 != 0 || DEPTH < 8) begin : g_bad_depth
            $error("DEPTH must be a positive multiple of 8");
        end
    endgenerate

    logic [5:0]       lvl_q;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] raw_stat;
    logic [IRQ_W-1:0] mstat;
    logic [IRQ_W-1:0] rd_mux;
    logic [EV_N-1:0]  ev_set;
    logic [EV_N-1:0]  ev_clr;
    logic [EV_N-1:0]  ev_pend;
    logic             rx_hit;
    logic             tx_hit;
    logic             clr_sel;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= LVL_RESET;
            mask_q <= '0;
        end else if (wr_en) begin
            if (reg_addr == A_LEVEL) lvl_q  <= wr_data[5:0];
            if (reg_addr == A_MASK)  mask_q <= wr_data & LIVE_BITS;
        end
    end

    uart_irq_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AT_LEAST(1'b1)) u_rx_thr (
        .code  (lvl_q[5:3]),
        .level (rx_level),
        .hit   (rx_hit)
    );

    uart_irq_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AT_LEAST(1'b0)) u_tx_thr (
        .code  (lvl_q[2:0]),
        .level (tx_level),
        .hit   (tx_hit)
    );

    assign clr_sel = wr_en && (reg_addr == A_CLEAR);
    assign ev_set  = {ev_overrun, ev_break, ev_parity_err, ev_frame_err, ev_rx_timeout};
    assign ev_clr  = clr_sel ? wr_data[B_OE:B_RTO] : '0;

    uart_irq_sticky #(.N(EV_N)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (ev_set),
        .clr_pulse (ev_clr),
        .pending   (ev_pend)
    );

    always_comb begin
        raw_stat              = '0;
        raw_stat[B_RX]        = rx_hit;
        raw_stat[B_TX]        = tx_hit;
        raw_stat[B_OE:B_RTO]  = ev_pend;
    end

    assign mstat = raw_stat & mask_q;
    assign irq   = |mstat;

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            A_LEVEL: rd_mux = {5'b0, lvl_q};
            A_MASK:  rd_mux = mask_q;
            A_RAW:   rd_mux = raw_stat;
            A_MSTAT: rd_mux = mstat;
            default: rd_mux = '0;
        endcase
    end

    assign rd_data = rd_en ? rd_mux : '0;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic             ev_frame_err,
    input logic             ev_parity_err,
    input logic             ev_overrun,
    input logic             wr_en,
    input logic [2:0]       reg_addr,
    input logic [10:0]      wr_data,
    input logic [10:0]      raw,
    input logic [10:0]      mask,
    input logic             irq
);
    logic clr_wr;
    assign clr_wr = wr_en && (reg_addr == 3'd2);

    assert_full_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= CNT_W'(DEPTH)) |-> raw[4]);

    assert_empty_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !raw[4]);

    assert_empty_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> raw[5]);

    assert_full_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level >= CNT_W'(DEPTH)) |-> !raw[5]);

    assert_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_err |=> raw[7]);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[8] && !(clr_wr && wr_data[8])) |=> raw[8]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wr_data[10] && !ev_overrun) |=> !raw[10]);

    assert_pulse_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wr_data[8] && ev_parity_err) |=> raw[8]);

    assert_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[3:0] == 4'b0) && (mask[3:0] == 4'b0));

    assert_irq_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw & mask) != 11'b0));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_level      (rx_level),
    .tx_level      (tx_level),
    .ev_frame_err  (ev_frame_err),
    .ev_parity_err (ev_parity_err),
    .ev_overrun    (ev_overrun),
    .wr_en         (wr_en),
    .reg_addr      (reg_addr),
    .wr_data       (wr_data),
    .raw           (raw_stat),
    .mask          (mask_q),
    .irq           (irq)
);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
    localparam int DEPTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] tx_level = '0;
    logic             ev_rx_timeout = 1'b0;
    logic             ev_frame_err = 1'b0;
    logic             ev_parity_err = 1'b0;
    logic             ev_break = 1'b0;
    logic             ev_overrun = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [10:0]      wr_data = '0;
    logic [10:0]      rd_data;
    logic             irq;

    int total = 0;
    int bad = 0;
    logic [10:0] exp_lat = '0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH)) u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .ev_rx_timeout(ev_rx_timeout), .ev_frame_err(ev_frame_err),
        .ev_parity_err(ev_parity_err), .ev_break(ev_break), .ev_overrun(ev_overrun),
        .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic int thr(input int code);
        int e;
        case (code)
            0: e = 1; 1: e = 2; 3: e = 6; 4: e = 7;
            default: e = 4;
        endcase
        return e * DEPTH / 8;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [10:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [10:0] v);
        reg_addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] ev);
        @(negedge clk);
        {ev_overrun, ev_break, ev_parity_err, ev_frame_err, ev_rx_timeout} = ev;
        @(negedge clk);
        {ev_overrun, ev_break, ev_parity_err, ev_frame_err, ev_rx_timeout} = '0;
    endtask

    task automatic t_reset();
        logic [10:0] v;
        rd(3'd0, v); check("R1 level reset", v, 11'h012);
        rd(3'd1, v); check("R1 mask reset", v, 0);
        rd(3'd3, v); check("R1 raw reset", v, 11'h020);
        check("R1 irq reset", irq, 0);
    endtask

    task automatic t_rx_codes();
        logic [10:0] v;
        tx_level = CNT_W'(DEPTH);
        for (int c = 0; c < 8; c++) begin
            wr(3'd0, 11'((c << 3) | 2));
            rx_level = CNT_W'(thr(c) - 1);
            rd(3'd3, v); check(c > 4 ? "R4 rx below" : "R2 rx below", v[4], 0);
            rx_level = CNT_W'(thr(c));
            rd(3'd3, v); check(c > 4 ? "R4 rx at" : "R2 rx at", v[4], 1);
        end
        rx_level = '0;
    endtask

    task automatic t_tx_codes();
        logic [10:0] v;
        for (int c = 0; c < 8; c++) begin
            wr(3'd0, 11'((2 << 3) | c));
            tx_level = CNT_W'(thr(c));
            rd(3'd3, v); check(c > 4 ? "R4 tx at" : "R3 tx at", v[5], 1);
            tx_level = CNT_W'(thr(c) + 1);
            rd(3'd3, v); check(c > 4 ? "R4 tx above" : "R3 tx above", v[5], 0);
        end
        wr(3'd0, 11'h012);
    endtask

    task automatic t_events();
        logic [10:0] v;
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i));
            exp_lat[6+i] = 1'b1;
            rd(3'd3, v); check("R5 event latch", v & 11'h7C0, exp_lat);
        end
        repeat (3) @(negedge clk);
        rd(3'd3, v); check("R5 event sticky", v & 11'h7C0, exp_lat);
    endtask

    task automatic t_clear();
        logic [10:0] v;
        wr(3'd2, 11'h080);  exp_lat[7] = 1'b0;
        rd(3'd3, v); check("R6 clear one", v & 11'h7C0, exp_lat);
        wr(3'd2, 11'h000);
        rd(3'd3, v); check("R6 clear zero", v & 11'h7C0, exp_lat);
        rx_level = CNT_W'(DEPTH); tx_level = '0;
        wr(3'd2, 11'h030);
        rd(3'd3, v); check("R6 level bits unaffected", v[5:4], 2'b11);
        rx_level = '0; tx_level = CNT_W'(DEPTH);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 3'd2; wr_data = 11'h100; ev_parity_err = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ev_parity_err = 1'b0;
        rd(3'd3, v); check("R7 pulse beats clear", v[8], 1);
        wr(3'd2, 11'h7C0); exp_lat = '0;
        rd(3'd3, v); check("R6 clear all", v, 0);
    endtask

    task automatic t_mask();
        logic [10:0] v;
        wr(3'd1, 11'h7FF);
        rd(3'd1, v); check("R8 mask low bits", v, 11'h7F0);
        check("R9 irq idle", irq, 0);
        pulse(5'b01000);    // break, bit 9
        rd(3'd4, v); check("R8 masked", v, 11'h200);
        check("R9 irq on", irq, 1);
        wr(3'd1, 11'h400);
        rd(3'd4, v); check("R8 masked off", v, 0);
        check("R9 irq masked", irq, 0);
        tx_level = '0;
        wr(3'd1, 11'h020);
        #1 check("R9 irq from tx level", irq, 1);
        tx_level = CNT_W'(DEPTH);
        #1 check("R9 irq follows level", irq, 0);
    endtask

    task automatic t_ro();
        logic [10:0] v;
        reg_addr = 3'd3; rd_en = 1'b0;
        #1 check("R10 read gated", rd_data, 0);
        wr(3'd3, 11'h000);
        wr(3'd4, 11'h7FF);
        rd(3'd3, v); check("R10 raw write ignored", v, 11'h200);
        rd(3'd1, v); check("R10 mask untouched", v, 11'h020);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_codes();
        t_tx_codes();
        t_events();
        t_clear();
        t_mask();
        t_ro();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule